// File: doc/BRIEF.md
# Speculative Load Data Buffer

This block keeps the data that speculative loads bring back, one slot per load-queue position. Each slot has two sub-blocks, one per cache line, so a load that straddles a line boundary is held as a first half and a second half. A slot remembers whether its access is split. Each sub-block keeps the byte address and size of its request and a full 64-byte line.

The core records a load on the issue port. The memory side then delivers lines on the fill port. A line is kept only when it belongs to the recorded request. A load whose line is already held by an older slot uses the forward port instead: the line comes from that source slot and the requested bytes return one cycle later. Later, the check port either exposes a held access or validates it. An expose only confirms that the address and size agree. A validate compares the held bytes at the access offset against a freshly fetched line and reports whether they are all equal. Three sticky error flags report malformed requests, forwards that find no source line, and checks that do not match the recorded access.

All request ports accept one request per cycle, with no back-pressure.

Top module: `spec_ld_buf`

## Requirements
- R1: An issue request records its byte address and size in sub-block 0 when `iss_second` is 0, or in sub-block 1 when it is 1. It also records `iss_split` as the slot's split flag.
- R2: A fill writes `fill_data` into the named sub-block only when bits [31:6] of the recorded address equal `fill_tag`. A fill with any other tag leaves the held line unchanged.
- R3: A forward reads source sub-block 0 when its line address matches bits [31:6] of `fwd_addr`, and otherwise reads sub-block 1 when that one matches. `rsp_data` byte k (bits 8k+7:8k) is source byte offset+k for k < size, and zero above, where the offset is `fwd_addr[5:0]`.
- R4: Every accepted forward produces exactly one `rsp_valid` pulse on the cycle after acceptance, carrying the destination slot in `rsp_slot`. Back-to-back forwards respond in acceptance order.
- R5: An accepted forward that finds a source line records the address and size in the destination sub-block and copies the source line into it.
- R6: A forward that matches neither source sub-block still responds, with `rsp_data` all zero, and sets `err[0]`.
- R7: A check (expose or validate) whose address or size differs from the recorded values of its sub-block, or that names sub-block 1 of a slot not marked split, sets `err[1]` and gives `chk_match` = 0.
- R8: A validate (`chk_validate` = 1) with matching address and size gives `chk_match` = 1 exactly when the held bytes from offset to offset+size-1 equal the same bytes of `chk_line`. Bytes outside that range have no effect.
- R9: Every check gives a `chk_done` pulse on the next cycle. An expose (`chk_validate` = 0) always gives `chk_match` = 0 and changes no held data.
- R10: An issue or forward is malformed when its size is 0, when offset plus size exceeds 64, when it names sub-block 1 without the split flag, or when its slot index is 33 or more. A malformed request sets `err[2]`, changes no state and produces no response.
- R11: All `err` bits are 0 after reset and stay set until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Record a speculative load |
| iss_slot | input | 6 | Slot index |
| iss_second | input | 1 | Sub-block select (1 = second half) |
| iss_split | input | 1 | Access crosses a line boundary |
| iss_addr | input | 32 | Byte address |
| iss_size | input | 7 | Size in bytes |
| fill_valid | input | 1 | Returned line present |
| fill_slot | input | 6 | Slot index |
| fill_second | input | 1 | Sub-block select |
| fill_tag | input | 26 | Line address of the returned line |
| fill_data | input | 512 | Line data, byte k at bits 8k+7:8k |
| fwd_valid | input | 1 | Buffer-only read |
| fwd_slot | input | 6 | Destination slot |
| fwd_second | input | 1 | Destination sub-block select |
| fwd_split | input | 1 | Destination access is split |
| fwd_src | input | 6 | Source slot |
| fwd_addr | input | 32 | Byte address |
| fwd_size | input | 7 | Size in bytes |
| rsp_valid | output | 1 | Forward response |
| rsp_slot | output | 6 | Destination slot of the response |
| rsp_data | output | 512 | Requested bytes, right-aligned |
| chk_valid | input | 1 | Expose or validate request |
| chk_validate | input | 1 | 1 = validate, 0 = expose |
| chk_slot | input | 6 | Slot index |
| chk_second | input | 1 | Sub-block select |
| chk_addr | input | 32 | Byte address |
| chk_size | input | 7 | Size in bytes |
| chk_line | input | 512 | Freshly fetched line |
| chk_done | output | 1 | Check result present |
| chk_match | output | 1 | Validate result |
| err | output | 3 | Sticky flags: 0 forward miss, 1 check mismatch, 2 malformed |

## Verification
Validation is tried with three lines: one identical to the held line, one that differs inside the access window, and one that differs only outside it. Together they separate a compare restricted to the window from a full-line compare and from a stuck result. Forwards are tried against a line present only in source sub-block 0, a line present only in sub-block 1, and a line in neither. These show the lookup order, the offset shift and the zero-fill of the miss response. A pair of back-to-back forwards checks that responses keep their order. Fills with a wrong tag, exposes and malformed forwards are each followed by a validate or a response check, which shows that they changed nothing.

// File: rtl/spec_ld_buf.sv
module spec_ld_buf #(
  parameter int SLOTS      = 33,
  parameter int LINE_BYTES = 64,
  parameter int ADDR_W     = 32,
  localparam int IDX_W  = $clog2(SLOTS),
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int SZ_W   = OFF_W + 1,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int TAG_W  = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [IDX_W-1:0]  iss_slot,
  input  logic              iss_second,
  input  logic              iss_split,
  input  logic [ADDR_W-1:0] iss_addr,
  input  logic [SZ_W-1:0]   iss_size,
  input  logic              fill_valid,
  input  logic [IDX_W-1:0]  fill_slot,
  input  logic              fill_second,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [LINE_W-1:0] fill_data,
  input  logic              fwd_valid,
  input  logic [IDX_W-1:0]  fwd_slot,
  input  logic              fwd_second,
  input  logic              fwd_split,
  input  logic [IDX_W-1:0]  fwd_src,
  input  logic [ADDR_W-1:0] fwd_addr,
  input  logic [SZ_W-1:0]   fwd_size,
  output logic              rsp_valid,
  output logic [IDX_W-1:0]  rsp_slot,
  output logic [LINE_W-1:0] rsp_data,
  input  logic              chk_valid,
  input  logic              chk_validate,
  input  logic [IDX_W-1:0]  chk_slot,
  input  logic              chk_second,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic [SZ_W-1:0]   chk_size,
  input  logic [LINE_W-1:0] chk_line,
  output logic              chk_done,
  output logic              chk_match,
  output logic [2:0]        err
);

  logic [ADDR_W-1:0] addr_q [SLOTS][2];
  logic [SZ_W-1:0]   size_q [SLOTS][2];
  logic [LINE_W-1:0] data_q [SLOTS][2];
  logic [SLOTS-1:0]  split_q;

  function automatic logic malformed(input logic [IDX_W-1:0] slot, input logic [ADDR_W-1:0] a,
                                     input logic [SZ_W-1:0] sz, input logic second, input logic split);
    logic [SZ_W:0] span;
    span = (SZ_W+1)'(a[OFF_W-1:0]) + (SZ_W+1)'(sz);
    return (sz == '0) || (span > (SZ_W+1)'(LINE_BYTES)) || (second && !split) ||
           (32'(slot) >= SLOTS);
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  logic iss_bad, iss_go;
  assign iss_bad = malformed(iss_slot, iss_addr, iss_size, iss_second, iss_split);
  assign iss_go  = iss_valid && !iss_bad;

  logic fill_go;
  assign fill_go = fill_valid && (32'(fill_slot) < SLOTS) &&
                   (tag_of(addr_q[fill_slot][fill_second]) == fill_tag);

  logic fwd_bad, fwd_go, hit0, hit1, fwd_hit;
  logic [LINE_W-1:0] src_line, fwd_bytes;
  assign fwd_bad = malformed(fwd_slot, fwd_addr, fwd_size, fwd_second, fwd_split) ||
                   (32'(fwd_src) >= SLOTS);
  assign fwd_go  = fwd_valid && !fwd_bad;
  assign hit0    = tag_of(addr_q[fwd_src][0]) == tag_of(fwd_addr);
  assign hit1    = tag_of(addr_q[fwd_src][1]) == tag_of(fwd_addr);
  assign fwd_hit = hit0 || hit1;
  assign src_line = hit0 ? data_q[fwd_src][0] : data_q[fwd_src][1];

  always_comb begin
    logic [LINE_W-1:0] shifted;
    shifted   = src_line >> {fwd_addr[OFF_W-1:0], 3'b000};
    fwd_bytes = '0;
    for (int b = 0; b < LINE_BYTES; b++)
      if (SZ_W'(b) < fwd_size) fwd_bytes[b*8 +: 8] = shifted[b*8 +: 8];
  end

  logic chk_exact, chk_same;
  logic [LINE_W-1:0] held_line;
  logic [SZ_W-1:0]   win_lo, win_hi;
  assign held_line = data_q[chk_slot][chk_second];
  assign chk_exact = (32'(chk_slot) < SLOTS) &&
                     (addr_q[chk_slot][chk_second] == chk_addr) &&
                     (size_q[chk_slot][chk_second] == chk_size) &&
                     (!chk_second || split_q[chk_slot]);
  assign win_lo = SZ_W'(chk_addr[OFF_W-1:0]);
  assign win_hi = win_lo + chk_size;

  always_comb begin
    chk_same = 1'b1;
    for (int b = 0; b < LINE_BYTES; b++)
      if (SZ_W'(b) >= win_lo && SZ_W'(b) < win_hi &&
          held_line[b*8 +: 8] != chk_line[b*8 +: 8])
        chk_same = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++)
        for (int h = 0; h < 2; h++) begin
          addr_q[s][h] <= '0;
          size_q[s][h] <= '0;
        end
      split_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_slot  <= '0;
      rsp_data  <= '0;
      chk_done  <= 1'b0;
      chk_match <= 1'b0;
      err       <= '0;
    end else begin
      if (iss_go) begin
        addr_q[iss_slot][iss_second] <= iss_addr;
        size_q[iss_slot][iss_second] <= iss_size;
        split_q[iss_slot]            <= iss_split;
      end
      if (fwd_go && fwd_hit) begin
        addr_q[fwd_slot][fwd_second] <= fwd_addr;
        size_q[fwd_slot][fwd_second] <= fwd_size;
        split_q[fwd_slot]            <= fwd_split;
      end
      rsp_valid <= fwd_go;
      rsp_slot  <= fwd_slot;
      rsp_data  <= fwd_hit ? fwd_bytes : '0;
      chk_done  <= chk_valid;
      chk_match <= chk_valid && chk_validate && chk_exact && chk_same;
      if (fwd_go && !fwd_hit) err[0] <= 1'b1;
      if (chk_valid && !chk_exact) err[1] <= 1'b1;
      if ((iss_valid && iss_bad) || (fwd_valid && fwd_bad)) err[2] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) data_q[fill_slot][fill_second] <= fill_data;
    if (fwd_go && fwd_hit) data_q[fwd_slot][fwd_second] <= src_line;
  end

endmodule

// File: rtl/spec_ld_buf_props.sv
module spec_ld_buf_props (
  input logic         clk,
  input logic         rst_n,
  input logic         fwd_valid,
  input logic         rsp_valid,
  input logic [511:0] rsp_data,
  input logic         chk_valid,
  input logic         chk_validate,
  input logic         chk_done,
  input logic         chk_match,
  input logic [2:0]   err
);

  assert_rsp_needs_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_valid |=> !rsp_valid);

  assert_chk_done_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> chk_done);

  assert_no_spurious_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !chk_done);

  assert_expose_no_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !chk_validate) |=> !chk_match);

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((err & $past(err)) == $past(err)));

  assert_miss_zero_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err[0]) |-> (rsp_valid && rsp_data == '0));

  assert_mismatch_no_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err[1]) |-> (chk_done && !chk_match));

endmodule

bind spec_ld_buf spec_ld_buf_props u_props (
  .clk(clk), .rst_n(rst_n), .fwd_valid(fwd_valid), .rsp_valid(rsp_valid),
  .rsp_data(rsp_data), .chk_valid(chk_valid), .chk_validate(chk_validate),
  .chk_done(chk_done), .chk_match(chk_match), .err(err)
);

// File: tb/spec_ld_buf_test.sv
`timescale 1ns/1ps
module spec_ld_buf_test;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic iss_valid = 0, iss_second = 0, iss_split = 0;
  logic [5:0] iss_slot = 0;
  logic [31:0] iss_addr = 0;
  logic [6:0] iss_size = 0;
  logic fill_valid = 0, fill_second = 0;
  logic [5:0] fill_slot = 0;
  logic [25:0] fill_tag = 0;
  logic [511:0] fill_data = 0;
  logic fwd_valid = 0, fwd_second = 0, fwd_split = 0;
  logic [5:0] fwd_slot = 0, fwd_src = 0;
  logic [31:0] fwd_addr = 0;
  logic [6:0] fwd_size = 0;
  logic rsp_valid;
  logic [5:0] rsp_slot;
  logic [511:0] rsp_data;
  logic chk_valid = 0, chk_validate = 0, chk_second = 0;
  logic [5:0] chk_slot = 0;
  logic [31:0] chk_addr = 0;
  logic [6:0] chk_size = 0;
  logic [511:0] chk_line = 0;
  logic chk_done, chk_match;
  logic [2:0] err;

  spec_ld_buf uut (.*);

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] mk_line(input logic [7:0] seed);
    logic [511:0] l;
    for (int b = 0; b < 64; b++) l[b*8 +: 8] = seed ^ 8'(b*7 + 1);
    return l;
  endfunction

  function automatic logic [511:0] pick(input logic [511:0] l, input int off, input int sz);
    logic [511:0] r = '0;
    for (int k = 0; k < sz; k++) r[k*8 +: 8] = l[(off+k)*8 +: 8];
    return r;
  endfunction

  logic [511:0] la, lb, l1, l2, l3;

  task automatic do_issue(input int slot, input bit second, input bit split, input logic [31:0] a, input int sz);
    @(negedge clk);
    iss_valid = 1; iss_slot = 6'(slot); iss_second = second; iss_split = split;
    iss_addr = a; iss_size = 7'(sz);
    @(negedge clk);
    iss_valid = 0;
  endtask

  task automatic do_fill(input int slot, input bit second, input logic [31:0] line_addr, input logic [511:0] d);
    @(negedge clk);
    fill_valid = 1; fill_slot = 6'(slot); fill_second = second;
    fill_tag = line_addr[31:6]; fill_data = d;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic do_chk(input bit validate, input int slot, input bit second, input logic [31:0] a,
                        input int sz, input logic [511:0] line, input bit exp_match, input string req);
    @(negedge clk);
    chk_valid = 1; chk_validate = validate; chk_slot = 6'(slot); chk_second = second;
    chk_addr = a; chk_size = 7'(sz); chk_line = line;
    @(negedge clk);
    chk_valid = 0;
    check(chk_done === 1'b1, {req, " done"}, 512'(chk_done), 512'(1));
    check(chk_match === exp_match, {req, " match"}, 512'(chk_match), 512'(exp_match));
  endtask

  task automatic set_fwd(input int slot, input int src, input logic [31:0] a, input int sz);
    fwd_valid = 1; fwd_slot = 6'(slot); fwd_src = 6'(src); fwd_second = 0; fwd_split = 0;
    fwd_addr = a; fwd_size = 7'(sz);
  endtask

  task automatic do_fwd(input int slot, input int src, input logic [31:0] a, input int sz,
                        input logic [511:0] exp, input string req);
    @(negedge clk);
    set_fwd(slot, src, a, sz);
    @(negedge clk);
    fwd_valid = 0;
    check(rsp_valid === 1'b1, {req, " rsp_valid"}, 512'(rsp_valid), 512'(1));
    check(rsp_slot === 6'(slot), {req, " rsp_slot"}, 512'(rsp_slot), 512'(slot));
    check(rsp_data === exp, {req, " rsp_data"}, rsp_data, exp);
    @(negedge clk);
    check(rsp_valid === 1'b0, {req, " single pulse"}, 512'(rsp_valid), 512'(0));
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check(err === 3'b000, "R11 reset err", 512'(err), 512'(0));
    check(rsp_valid === 1'b0, "R4 reset rsp_valid", 512'(rsp_valid), 512'(0));
    check(chk_done === 1'b0, "R9 reset chk_done", 512'(chk_done), 512'(0));
  endtask

  task automatic t_fill_validate;
    do_issue(3, 0, 0, 32'h1000_0010, 8);
    do_fill(3, 0, 32'h1000_0000, l1);
    do_chk(1, 3, 0, 32'h1000_0010, 8, l1, 1, "R1 R8 validate equal");
    do_chk(1, 3, 0, 32'h1000_0010, 8, l2, 0, "R8 differ inside window");
    do_chk(1, 3, 0, 32'h1000_0010, 8, l3, 1, "R8 differ outside window");
    do_fill(3, 0, 32'h2000_0000, l2);
    do_chk(1, 3, 0, 32'h1000_0010, 8, l1, 1, "R2 wrong tag ignored");
  endtask

  task automatic t_split_forward;
    do_issue(5, 0, 1, 32'h0000_3038, 8);
    do_issue(5, 1, 1, 32'h0000_3040, 8);
    do_fill(5, 0, 32'h0000_3000, la);
    do_fill(5, 1, 32'h0000_3040, lb);
    do_chk(1, 5, 1, 32'h0000_3040, 8, lb, 1, "R1 second half held");
    do_chk(1, 5, 1, 32'h0000_3040, 8, la, 0, "R1 second half differs");
    do_chk(1, 5, 0, 32'h0000_3038, 8, la, 1, "R1 first half held");
    do_fwd(7, 5, 32'h0000_3044, 4, pick(lb, 4, 4), "R3 source sub-block 1");
    do_fwd(6, 5, 32'h0000_3000, 4, pick(la, 0, 4), "R3 source sub-block 0");
    do_chk(1, 7, 0, 32'h0000_3044, 4, lb, 1, "R5 destination copy");
    do_chk(1, 7, 0, 32'h0000_3044, 4, la, 0, "R5 destination copy differs");
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    set_fwd(8, 5, 32'h0000_3039, 3);
    @(negedge clk);
    set_fwd(9, 5, 32'h0000_3041, 5);
    check(rsp_valid === 1'b1 && rsp_slot === 6'd8, "R4 first in order", 512'(rsp_slot), 512'(8));
    check(rsp_data === pick(la, 57, 3), "R3 R4 first data", rsp_data, pick(la, 57, 3));
    @(negedge clk);
    fwd_valid = 0;
    check(rsp_valid === 1'b1 && rsp_slot === 6'd9, "R4 second in order", 512'(rsp_slot), 512'(9));
    check(rsp_data === pick(lb, 1, 5), "R3 R4 second data", rsp_data, pick(lb, 1, 5));
    @(negedge clk);
    check(rsp_valid === 1'b0, "R4 no extra response", 512'(rsp_valid), 512'(0));
  endtask

  task automatic t_expose;
    do_chk(0, 7, 0, 32'h0000_3044, 4, la, 0, "R9 expose");
    check(err === 3'b000, "R9 expose no error", 512'(err), 512'(0));
    do_chk(1, 7, 0, 32'h0000_3044, 4, lb, 1, "R9 expose left data");
  endtask

  task automatic t_errors;
    @(negedge clk);
    set_fwd(11, 5, 32'h0000_307E, 4);
    @(negedge clk);
    fwd_valid = 0;
    check(rsp_valid === 1'b0, "R10 malformed no response", 512'(rsp_valid), 512'(0));
    check(err === 3'b100, "R10 malformed flag", 512'(err), 512'(3'b100));
    do_chk(1, 11, 0, 32'h0000_307E, 4, lb, 0, "R10 R7 dropped forward unrecorded");
    check(err === 3'b110, "R7 mismatch flag", 512'(err), 512'(3'b110));
    do_chk(1, 7, 0, 32'h0000_3044, 2, lb, 0, "R7 size mismatch");
    do_chk(1, 3, 1, 32'h0000_0000, 0, l1, 0, "R7 second half of unsplit slot");
    do_fwd(12, 3, 32'h0000_5000, 4, '0, "R6 forward miss");
    check(err === 3'b111, "R6 miss flag", 512'(err), 512'(3'b111));
    repeat (3) @(negedge clk);
    check(err === 3'b111, "R11 flags held", 512'(err), 512'(3'b111));
    t_reset();
  endtask

  initial begin
    la = mk_line(8'h10);
    lb = mk_line(8'h5a);
    l1 = mk_line(8'h21);
    l2 = l1; l2[8'h12*8 +: 8] = ~l1[8'h12*8 +: 8];
    l3 = l1; l3[8'h30*8 +: 8] = ~l1[8'h30*8 +: 8];
    t_reset();
    t_fill_validate();
    t_split_forward();
    t_back_to_back();
    t_expose();
    t_errors();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule